// File: doc/BRIEF.md
# Multi-mode test register: scan, pattern generation and signature compaction

This block is a small register that serves the test logic placed around a piece of combinational logic. A two-bit mode input picks one of four behaviours for every clock edge. The register can shift serially as a link in a scan chain, or load a parallel word as an ordinary pipeline register. It can clear itself synchronously. In self-test mode it runs as a maximal-length linear feedback shift register.

In self-test mode the parallel data word is XORed into the next state on every edge. With the data held at zero the register produces pseudo-random stimulus. With the response of the logic under test fed in, it folds that response stream into a signature. The comparison of the signature against a golden value is done elsewhere.

The width and the feedback tap mask are parameters. The defaults give the 3-bit register with a period-7 sequence.

Top module: `bilbo_reg`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `q` is 3'b000.
- R2: With `mode` = 2'b00 (shift), each clock sets `q[0]` to `scan_in` and `q[i]` to the previous `q[i-1]`. `scan_out` always equals `q[2]`.
- R3: With `mode` = 2'b11 (load), each clock copies `d` into `q`, bit for bit.
- R4: With `mode` = 2'b10 (clear), the next clock sets `q` to 3'b000, whatever `d` and `scan_in` are.
- R5: With `mode` = 2'b01 (self-test), each clock sets `q[0]` to `q[1]^d[0]`, `q[1]` to `q[2]^d[1]`, and `q[2]` to `q[0]^q[2]^d[2]`.
- R6: In self-test with `d` = 0, starting from `q` = 3'b111, the values of `q` on successive clocks are 3'b011, 3'b101, 3'b010, 3'b001, 3'b100, 3'b110, and then 3'b111 again (period 7). A nonzero state never becomes zero.
- R7: A new mode acts on the first clock edge at which it is sampled. The state built up in the previous mode is the starting point, with no lost or extra cycle.
- R8: From `q` = 3'b000 in self-test, compacting the data stream 3'b011, 3'b101, 3'b110, 3'b001 leaves the signature 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 shift, 01 self-test, 10 clear, 11 load |
| d | input | 3 | Parallel data or response word |
| scan_in | input | 1 | Serial input into bit 0 |
| q | output | 3 | Register state |
| scan_out | output | 1 | Serial output, equal to q[2] |

## Verification
The bench builds the block with its default width of 3 and tap mask 3'b101. With these values the whole 7-state orbit, a full scan shift-through and a hand-worked signature are short enough to check cycle by cycle against a table. The bench also switches between modes directly from one cycle to the next, so that a carried-over state is checked at every transition.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT    = 2'b00,
    MODE_SELFTEST = 2'b01,
    MODE_CLEAR    = 2'b10,
    MODE_LOAD     = 2'b11
  } bilbo_mode_e;

  localparam int NUM_MODES = 4;
endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
  import bilbo_pkg::*;
(
  input  logic [1:0]           mode,
  output logic [NUM_MODES-1:0] sel
);
  bilbo_mode_e m;
  assign m = bilbo_mode_e'(mode);

  always_comb begin
    sel = '0;
    case (m)
      MODE_SHIFT:    sel[0] = 1'b1;
      MODE_SELFTEST: sel[1] = 1'b1;
      MODE_CLEAR:    sel[2] = 1'b1;
      MODE_LOAD:     sel[3] = 1'b1;
      default:       sel = '0;
    endcase
  end
endmodule

// File: rtl/bilbo_next.sv
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int          W    = 3,
  parameter logic [W-1:0] TAPS = 3'b101
) (
  input  logic [NUM_MODES-1:0] sel,
  input  logic [W-1:0]         q,
  input  logic [W-1:0]         d,
  input  logic                 si,
  output logic [W-1:0]         nxt,
  output logic                 fb_bit
);
  function automatic logic [W-1:0] step_lfsr(input logic [W-1:0] s,
                                             input logic [W-1:0] din);
    logic [W-1:0] r;
    r = {^(s & TAPS), s[W-1:1]} ^ din;
    return r;
  endfunction

  function automatic logic [W-1:0] step_scan(input logic [W-1:0] s,
                                             input logic sin);
    logic [W-1:0] r;
    r = {s[W-2:0], sin};
    return r;
  endfunction

  logic [W-1:0] nxt_shift, nxt_test;
  assign fb_bit    = ^(q & TAPS);
  assign nxt_shift = step_scan(q, si);
  assign nxt_test  = step_lfsr(q, d);

  always_comb begin
    nxt = q;
    if (sel[0]) nxt = nxt_shift;
    if (sel[1]) nxt = nxt_test;
    if (sel[2]) nxt = '0;
    if (sel[3]) nxt = d;
  end
endmodule

// File: rtl/bilbo_state.sv
module bilbo_state #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int          W    = 3,
  parameter logic [W-1:0] TAPS = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] d,
  input  logic         scan_in,
  output logic [W-1:0] q,
  output logic         scan_out
);
  logic [NUM_MODES-1:0] sel;
  logic [W-1:0]         nxt;
  logic                 fb_bit;
  logic                 gen_active;

  bilbo_mode_dec u_dec (.mode(mode), .sel(sel));

  bilbo_next #(.W(W), .TAPS(TAPS)) u_next (
    .sel(sel), .q(q), .d(d), .si(scan_in), .nxt(nxt), .fb_bit(fb_bit)
  );

  bilbo_state #(.W(W)) u_state (.clk(clk), .rst_n(rst_n), .nxt(nxt), .q(q));

  assign scan_out   = q[W-1];
  assign gen_active = (mode == 2'b01) && (d == '0);

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (q == '0); // R1
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel)); // R7
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (q[0] == $past(scan_in)) && (q[W-1:1] == $past(q[W-2:0]))); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (q == $past(d))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (q == '0)); // R4
  AST_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (q[W-2:0] == $past(q[W-1:1] ^ d[W-2:0]))); // R5
  AST_TEST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (q[W-1] == $past(fb_bit ^ d[W-1]))); // R5
  AST_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_active && (q != '0)) |=> (q != '0)); // R6
endmodule

// File: tb/test_bilbo_reg.sv
`timescale 1ns/1ps
module test_bilbo_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] d = 3'b000;
  logic       scan_in = 1'b0;
  logic [2:0] q;
  logic       scan_out;

  int checks = 0;
  int errors = 0;
  logic [2:0] mq = 3'b000;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  bilbo_reg i_bilbo_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .d(d),
    .scan_in(scan_in), .q(q), .scan_out(scan_out)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, ex);
    end
  endtask

  // Driver: drives inputs at the falling edge and pushes the expected state.
  task automatic step(input logic [1:0] m, input logic [2:0] dv, input logic sv,
                      input string tag, input bit use_tbl = 1'b0,
                      input logic [2:0] tv = 3'b000);
    logic [2:0] n;
    @(negedge clk);
    mode = m; d = dv; scan_in = sv;
    case (m)
      2'b00: n = {mq[1], mq[0], sv};
      2'b01: n = {mq[0] ^ mq[2] ^ dv[2], mq[2] ^ dv[1], mq[1] ^ dv[0]};
      2'b10: n = 3'b000;
      default: n = dv;
    endcase
    if (use_tbl) n = tv;
    mq = n;
    exp_q.push_back({n[2], n});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one expected entry per clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {scan_out, q}, e);
    end
  end

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] orbit[7];
    orbit = '{3'b011, 3'b101, 3'b010, 3'b001, 3'b100, 3'b110, 3'b111};
    mode = 2'b11; d = 3'b111;
    #9;
    check("R1 reset", {scan_out, q}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 loads
    step(2'b11, 3'b101, 1'b0, "R3 load 101");
    step(2'b11, 3'b010, 1'b1, "R3 load 010");
    // R2 shift-through, R7 switch from load
    step(2'b00, 3'b111, 1'b1, "R2 R7 shift after load");
    step(2'b00, 3'b000, 1'b0, "R2 shift 0");
    step(2'b00, 3'b111, 1'b1, "R2 shift 1");
    step(2'b00, 3'b000, 1'b1, "R2 shift 1b");
    // R4 clear with busy inputs
    step(2'b10, 3'b111, 1'b1, "R4 clear");
    step(2'b10, 3'b101, 1'b0, "R4 clear held");
    // R5 arbitrary compaction, R7 switch from clear and load
    step(2'b11, 3'b100, 1'b0, "R3 load 100");
    step(2'b01, 3'b010, 1'b1, "R5 R7 test after load");
    step(2'b01, 3'b111, 1'b0, "R5 test d=111");
    step(2'b01, 3'b001, 1'b0, "R5 test d=001");
    // R6 orbit from 111 with d = 0
    step(2'b11, 3'b111, 1'b0, "R3 seed 111");
    for (int k = 0; k < 14; k++)
      step(2'b01, 3'b000, 1'b0, "R6 orbit", 1'b1, orbit[k % 7]);
    // R8 signature from zero
    step(2'b10, 3'b000, 1'b0, "R4 clear before signature");
    step(2'b01, 3'b011, 1'b0, "R8 compact 1");
    step(2'b01, 3'b101, 1'b0, "R8 compact 2");
    step(2'b01, 3'b110, 1'b0, "R8 compact 3");
    step(2'b01, 3'b001, 1'b0, "R8 compact 4");
    wait (exp_q.size() == 0);
    check("R8 signature", {1'b0, q}, 4'b0110);
    @(negedge clk);
    mode = 2'b11; d = 3'b000;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule